// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fast reference clock into the two enables a UART needs: a sample tick at the oversampling rate and a bit tick once per bit period. Software works out the divisor outside the block, as Fref / (c × baud), where c is the oversampling ratio. It writes the integer part, a 4-bit fraction in sixteenths and a rate mode into three write-only configuration registers. The rate mode sets c to 16, 8 or 4.

The fraction is applied by accumulation. At each divider period the fraction is added into a 4-bit accumulator. A period in which that addition carries lasts one reference cycle longer than the integer divisor. Over any sixteen periods the total extra length is exactly the fraction, so the average period equals the programmed divisor. The 8x and 4x modes lower the oversampling ratio so that line rates too high for 16x can be reached. They also cut noise tolerance, so they are a fallback rather than a default. An integer divisor below 16 is legal. A divisor of zero is treated as one, so the generator never stalls.

Any register write restarts the dividers in the same clock edge that loads the new value. This gives software a known phase from which the first tick is counted.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is high, both ticks are low. Reset loads integer divisor 1, fraction 0 and mode x1. After release, a sample tick appears on every cycle and a bit tick on every 16th cycle.
- R2: With fraction 0 and integer divisor N of 2 or more, sample ticks are single-cycle pulses spaced exactly N cycles apart.
- R3: With integer divisor N and fraction f (0..15), sample tick number k (k = 1, 2, ...) counted from the restart edge appears k·N + floor(k·f/16) cycles after that edge. Each period is therefore N or N+1 cycles long.
- R4: Integer divisors below 16 are honoured. Divisor 1 with fraction 0 keeps the sample tick high on every cycle.
- R5: An integer divisor of 0 behaves exactly as a divisor of 1, with the fraction still applied.
- R6: The mode field (2 bits) selects the samples per bit: code 0 gives 16, code 1 gives 8, code 2 gives 4. The bit tick rises only together with a sample tick, on every c-th sample tick after a restart.
- R7: Mode code 3 is reserved and behaves as code 0 (16 samples per bit).
- R8: A write to any one of the three registers, even with an unchanged value, restarts the divider counter, the fraction accumulator and the sample count at that edge. The other two registers keep their values. The next cycle never carries a bit tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| int_we | input | 1 | Write strobe for the integer divisor |
| int_wdata | input | INT_W | Integer divisor value |
| frac_we | input | 1 | Write strobe for the fraction |
| frac_wdata | input | FRAC_W | Fraction in sixteenths |
| mode_we | input | 1 | Write strobe for the rate mode |
| mode_wdata | input | 2 | Rate mode code (0: 16x, 1: 8x, 2: 4x, 3: as 0) |
| sample_tick | output | 1 | Oversampling enable, one cycle wide |
| bit_tick | output | 1 | Bit-rate enable, coincident with a sample tick |

## Verification
The hardest situation to reach from the ports is a restart that lands mid-period, with the accumulator part-filled and the sample count part-way to a bit tick. If it is missed, the next ticks inherit stale phase.

The stimulus lets a divisor with a nonzero fraction run for a while. It then rewrites one register with its own value, and later rewrites a different register with a new value. Each time, the whole tick schedule is checked afresh from the write edge.

Random divisors, fractions and modes, including zero and the reserved mode, are checked cycle by cycle against the closed-form tick times in R3 and R6.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  typedef enum logic [1:0] {
    RATE_X1  = 2'd0,
    RATE_X2  = 2'd1,
    RATE_X4  = 2'd2,
    RATE_RSV = 2'd3
  } rate_mode_e;

  localparam int SPB_W = 4;

  // samples per bit minus one, per rate mode (reserved code maps to x1)
  function automatic logic [SPB_W-1:0] spb_m1(input rate_mode_e m);
    case (m)
      RATE_X2: spb_m1 = SPB_W'(7);
      RATE_X4: spb_m1 = SPB_W'(3);
      default: spb_m1 = SPB_W'(15);
    endcase
  endfunction

endpackage

// File: rtl/fbg_cfg_regs.sv
module fbg_cfg_regs
  import fbg_pkg::*;
#(
  parameter int INT_W   = 16,
  parameter int FRAC_W  = 4,
  parameter int RST_INT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_we,
  input  logic [INT_W-1:0]  int_wdata,
  input  logic              frac_we,
  input  logic [FRAC_W-1:0] frac_wdata,
  input  logic              mode_we,
  input  logic [1:0]        mode_wdata,
  output logic [INT_W-1:0]  div_int,
  output logic [FRAC_W-1:0] div_frac,
  output rate_mode_e        rate_mode,
  output logic              restart
);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_int   <= INT_W'(RST_INT);
      div_frac  <= '0;
      rate_mode <= RATE_X1;
    end else begin
      if (int_we)  div_int   <= int_wdata;
      if (frac_we) div_frac  <= frac_wdata;
      if (mode_we) rate_mode <= rate_mode_e'(mode_wdata);
    end
  end

  // any write realigns the dividers in the same edge that loads the value
  assign restart = int_we | frac_we | mode_we;

endmodule

// File: rtl/fbg_frac_div.sv
module fbg_frac_div #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick_pre,
  output logic              sample_tick
);

  localparam int CNT_W = INT_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W-1:0] acc_sum;
  logic              carry;
  logic [INT_W-1:0]  n_eff;
  logic [CNT_W-1:0]  len_m1;

  always_comb begin
    n_eff            = (div_int == '0) ? INT_W'(1) : div_int;
    {carry, acc_sum} = {1'b0, acc} + {1'b0, div_frac};
    len_m1           = CNT_W'(n_eff) - CNT_W'(1) + CNT_W'(carry);
    tick_pre         = (cnt >= len_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt         <= '0;
      acc         <= '0;
      sample_tick <= 1'b0;
    end else if (tick_pre) begin
      cnt         <= '0;
      acc         <= acc_sum;
      sample_tick <= 1'b1;
    end else begin
      cnt         <= cnt + CNT_W'(1);
      sample_tick <= 1'b0;
    end
  end

endmodule

// File: rtl/fbg_bit_div.sv
module fbg_bit_div
  import fbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       tick_pre,
  input  rate_mode_e rate_mode,
  output logic       bit_tick
);

  logic [SPB_W-1:0] scnt;
  logic [SPB_W-1:0] last_idx;

  assign last_idx = spb_m1(rate_mode);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      scnt     <= '0;
      bit_tick <= 1'b0;
    end else if (tick_pre) begin
      if (scnt >= last_idx) begin
        scnt     <= '0;
        bit_tick <= 1'b1;
      end else begin
        scnt     <= scnt + SPB_W'(1);
        bit_tick <= 1'b0;
      end
    end else begin
      bit_tick <= 1'b0;
    end
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int INT_W   = 16,
  parameter int FRAC_W  = 4,
  parameter int RST_INT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_we,
  input  logic [INT_W-1:0]  int_wdata,
  input  logic              frac_we,
  input  logic [FRAC_W-1:0] frac_wdata,
  input  logic              mode_we,
  input  logic [1:0]        mode_wdata,
  output logic              sample_tick,
  output logic              bit_tick
);

  logic [INT_W-1:0]  div_int;
  logic [FRAC_W-1:0] div_frac;
  rate_mode_e        rate_mode;
  logic              restart;
  logic              tick_pre;

  fbg_cfg_regs #(
    .INT_W   (INT_W),
    .FRAC_W  (FRAC_W),
    .RST_INT (RST_INT)
  ) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .int_we     (int_we),
    .int_wdata  (int_wdata),
    .frac_we    (frac_we),
    .frac_wdata (frac_wdata),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .div_int    (div_int),
    .div_frac   (div_frac),
    .rate_mode  (rate_mode),
    .restart    (restart)
  );

  fbg_frac_div #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
  ) u_frac (
    .clk         (clk),
    .rst         (rst),
    .restart     (restart),
    .div_int     (div_int),
    .div_frac    (div_frac),
    .tick_pre    (tick_pre),
    .sample_tick (sample_tick)
  );

  fbg_bit_div u_bit (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .tick_pre  (tick_pre),
    .rate_mode (rate_mode),
    .bit_tick  (bit_tick)
  );

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              int_we,
  input logic              frac_we,
  input logic              mode_we,
  input logic [INT_W-1:0]  div_int,
  input logic [FRAC_W-1:0] div_frac,
  input logic [1:0]        rate_mode,
  input logic              sample_tick,
  input logic              bit_tick
);

  localparam int GAP_W = INT_W + 2;

  logic             any_we;
  logic [GAP_W-1:0] gap;
  logic [GAP_W-1:0] n_chk;
  logic [4:0]       sc;
  logic [4:0]       c_m1;

  assign any_we = int_we | frac_we | mode_we;
  assign n_chk  = (div_int == '0) ? GAP_W'(1) : GAP_W'(div_int);
  assign c_m1   = (rate_mode == 2'd1) ? 5'd7 : (rate_mode == 2'd2) ? 5'd3 : 5'd15;

  always_ff @(posedge clk) begin
    if (rst || any_we) begin
      gap <= '0;
      sc  <= '0;
    end else begin
      gap <= sample_tick ? GAP_W'(1) : gap + GAP_W'(1);
      if (sample_tick) sc <= bit_tick ? 5'd0 : sc + 5'd1;
    end
  end

  assert_period_bounds_R3: assert property (@(posedge clk) disable iff (rst)
    sample_tick |-> (gap >= n_chk && gap <= n_chk + GAP_W'(1)));

  assert_no_late_tick_R3: assert property (@(posedge clk) disable iff (rst)
    gap <= n_chk + GAP_W'(1));

  assert_exact_period_R2: assert property (@(posedge clk) disable iff (rst)
    (sample_tick && div_frac == '0) |-> gap == n_chk);

  assert_zero_as_one_R5: assert property (@(posedge clk) disable iff (rst)
    (div_int == '0 && div_frac == '0 && !any_we) |=> sample_tick);

  assert_bit_on_sample_R6: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sample_tick);

  assert_bit_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sc == c_m1);

  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (rst)
    any_we |=> !bit_tick);

endmodule

bind frac_baud_gen frac_baud_gen_chk #(
  .INT_W  (INT_W),
  .FRAC_W (FRAC_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .int_we      (int_we),
  .frac_we     (frac_we),
  .mode_we     (mode_we),
  .div_int     (div_int),
  .div_frac    (div_frac),
  .rate_mode   (rate_mode),
  .sample_tick (sample_tick),
  .bit_tick    (bit_tick)
);

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;

  localparam int CLK_PERIOD = 10;
  localparam int INT_W      = 16;
  localparam int FRAC_W     = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              int_we = 1'b0;
  logic [INT_W-1:0]  int_wdata = '0;
  logic              frac_we = 1'b0;
  logic [FRAC_W-1:0] frac_wdata = '0;
  logic              mode_we = 1'b0;
  logic [1:0]        mode_wdata = '0;
  logic              sample_tick;
  logic              bit_tick;

  int n_checks = 0;
  int n_fail   = 0;
  int cur_n, cur_f, cur_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_baud_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rst(rst),
    .int_we(int_we), .int_wdata(int_wdata),
    .frac_we(frac_we), .frac_wdata(frac_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // sample tick k lands at k*n + floor(k*f/16) cycles after restart (R3)
  function automatic int tick_idx(input int i, input int n, input int f);
    for (int k = 1; k * n <= i; k++)
      if (k * n + (k * f) / 16 == i) return k;
    return 0;
  endfunction

  function automatic int spb(input int m);
    return (m == 1) ? 8 : (m == 2) ? 4 : 16;
  endfunction

  // compares both ticks for 'cycles' cycles after the restart edge
  task automatic observe(input int cycles, input string req);
    int n, k, bad_s, bad_b, first_s, first_b, act_s, act_b;
    bit es, eb;
    n = (cur_n == 0) ? 1 : cur_n;
    bad_s = 0; bad_b = 0; first_s = 0; first_b = 0; act_s = 0; act_b = 0;
    for (int i = 1; i <= cycles; i++) begin
      @(negedge clk);
      k  = tick_idx(i, n, cur_f);
      es = (k != 0);
      eb = (k != 0) && (k % spb(cur_m) == 0);
      if (sample_tick !== es) begin
        if (bad_s == 0) begin first_s = i; act_s = int'(sample_tick); end
        bad_s++;
      end
      if (bit_tick !== eb) begin
        if (bad_b == 0) begin first_b = i; act_b = int'(bit_tick); end
        bad_b++;
      end
    end
    check(bad_s == 0, req, $sformatf("sample_tick n=%0d f=%0d m=%0d first bad cycle %0d",
          cur_n, cur_f, cur_m, first_s), act_s, int'(!act_s[0]));
    check(bad_b == 0, req, $sformatf("bit_tick n=%0d f=%0d m=%0d first bad cycle %0d",
          cur_n, cur_f, cur_m, first_b), act_b, int'(!act_b[0]));
  endtask

  // called at a negedge; the following posedge is the restart edge
  task automatic write_regs(input bit wi, input int vi, input bit wf, input int vf,
                            input bit wm, input int vm);
    int_we = wi; int_wdata = INT_W'(vi);
    frac_we = wf; frac_wdata = FRAC_W'(vf);
    mode_we = wm; mode_wdata = 2'(vm);
    if (wi) cur_n = vi;
    if (wf) cur_f = vf;
    if (wm) cur_m = vm;
    @(negedge clk);
    int_we = 1'b0; frac_we = 1'b0; mode_we = 1'b0;
  endtask

  function automatic int span();
    int n;
    n = (cur_n == 0) ? 1 : cur_n;
    return spb(cur_m) * (n + 1) * 2 + 8;
  endfunction

  task automatic scenario(input int vi, input int vf, input int vm, input string req);
    write_regs(1'b1, vi, 1'b1, vf, 1'b1, vm);
    observe(span(), req);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    int seed, vi, vf, vm;
    seed = $urandom(32'd1234);
    // R1: outputs low during reset
    repeat (3) begin
      @(negedge clk);
      check(sample_tick === 1'b0 && bit_tick === 1'b0, "R1", "ticks in reset",
            int'({sample_tick, bit_tick}), 0);
    end
    // R1: defaults after release (divisor 1, fraction 0, x1)
    cur_n = 1; cur_f = 0; cur_m = 0;
    rst = 1'b0;
    observe(40, "R1");
    scenario(5, 0, 0, "R2");       // R2 integer only
    scenario(5, 3, 1, "R3");       // R3 fraction, x2
    scenario(3, 15, 2, "R3_R4");   // R3 R4 max fraction, small divisor, x4
    scenario(1, 0, 2, "R4");       // R4 tick every cycle
    scenario(0, 0, 0, "R5");       // R5 zero as one
    scenario(0, 8, 1, "R5");       // R5 zero as one with fraction
    scenario(2, 4, 3, "R7");       // R7 reserved mode as x1
    // R8: restarts mid-period via single-register writes
    write_regs(1'b1, 7, 1'b1, 5, 1'b1, 1);
    observe(37, "R8");
    write_regs(1'b0, 0, 1'b1, 5, 1'b0, 0);   // same fraction rewritten
    observe(53, "R8");
    write_regs(1'b1, 4, 1'b0, 0, 1'b0, 0);   // new integer, others kept
    observe(span(), "R8");
    write_regs(1'b0, 0, 1'b0, 0, 1'b1, 2);   // mode only
    observe(span(), "R8_R6");
    // random mix, R3 and R6
    for (int r = 0; r < 8; r++) begin
      vi = $urandom_range(0, 12);
      vf = $urandom_range(0, 15);
      vm = $urandom_range(0, 3);
      scenario(vi, vf, vm, "R3_R6");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule